// File: doc/BRIEF.md
# Switcher Fault Protection Sequencer

This block supervises an off-line switching regulator. It decides when the power stage may switch, holds drive off through timed recovery periods after faults, and produces a peak-current setpoint code that ramps from zero to full scale at the start of every run. All of its inputs are already-digitized flags: supply-rail comparators (start threshold, under-voltage, over-voltage), a peak-current-limit flag, thermal shutdown, brown-out, and a timebase tick that paces every duration.

A single interval timer serves two purposes. During a run it measures how long current limit has been held continuously. After a trip it measures the off period. This repeated trip-and-wait cycle produces a low-duty hiccup burst under a sustained overload. An over-voltage flag must persist for a filter window before it counts, and it then forces the same timed off period. Thermal shutdown, brown-out and rail under-voltage stop drive at once, and the block then waits for a fresh start condition. Every path back into switching restarts the soft-start ramp from zero.

Durations are set by parameters in tick units. `MS_TICKS` gives the ticks per millisecond. The millisecond windows are `FAULT_MS`, `OFF_MS` and `SS_MS`, and the over-voltage filter is `OVF_TICKS` fine ticks. In the formulas below, FAULT_TICKS = FAULT_MS*MS_TICKS, OFF_TICKS = OFF_MS*MS_TICKS and SS_STEP = (SS_MS*MS_TICKS)/(2^CODE_W-1), with a minimum of 1.

Top module: `switcher_fault_seq`

## Requirements
- R1: While rst_ni is low, and in the cycle after it rises, drive_en_o=0, ipk_code_o=0 and state_o=0. The encoding of state_o is 0 for wait-for-start, 1 for run and 2 for recovery.
- R2: In wait-for-start, the block enters run (state_o=1, drive_en_o=1) at the first clock edge that samples rail_start_i=1 with rail_low_i, tsd_i and bo_i all 0. drive_en_o is 1 exactly when state_o=1.
- R3: In run, ipk_code_o starts at 0 and rises by 1 after every SS_STEP ticks (clock edges with tick_i=1). It saturates at 2^CODE_W-1. It does not advance on edges with tick_i=0.
- R4: ipk_code_o is 0 whenever drive_en_o is 0, so every new run starts its ramp at 0.
- R5: In run, if ilim_i is sampled 1 on FAULT_TICKS consecutive ticks, the block enters recovery (state_o=2) at the last of those edges.
- R6: If ilim_i is sampled 0 on any edge during run, the overload count returns to zero, and a full FAULT_TICKS window of ilim_i=1 is then needed to trip.
- R7: Recovery lasts OFF_TICKS ticks. The block then goes to wait-for-start, never straight to run. A persisting overload therefore repeats run and recovery, and a cleared overload leaves run uninterrupted.
- R8: rail_ov_i qualifies after it is sampled 1 on OVF_TICKS consecutive ticks, and a 0 restarts the filter. A qualified over-voltage in run moves the block to recovery at the next edge. Shorter pulses have no effect.
- R9: rail_low_i=1 in run moves the block to wait-for-start at the next edge.
- R10: tsd_i=1 or bo_i=1 in run moves the block to wait-for-start at the next edge. These inputs take priority over over-voltage and overload, and a start is blocked while either is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase tick, one cycle wide |
| rail_start_i | input | 1 | Supply rail at or above its start threshold |
| rail_low_i | input | 1 | Supply rail at or below its turn-off level |
| rail_ov_i | input | 1 | Supply rail over-voltage comparator |
| ilim_i | input | 1 | Peak-current limit reached |
| tsd_i | input | 1 | Thermal shutdown |
| bo_i | input | 1 | Brown-out |
| drive_en_o | output | 1 | Switching permitted |
| ipk_code_o | output | CODE_W | Peak-current setpoint code |
| state_o | output | 2 | 0 wait-for-start, 1 run, 2 recovery |

## Verification
The bench places the overload trip on the exact tick that completes the window. A timer that is off by one, or that keeps its count across a short gap in ilim_i, would trip one edge early or late, or too soon after the gap. It drives over-voltage pulses one tick short of the filter length and exactly at it, so a filter that does not restart, or one that acts without filtering, is caught. It follows a persisting overload and a persisting over-voltage through whole recovery cycles. A block that skipped wait-for-start, mistimed the off period, or resumed the ramp at a non-zero code would show the wrong state or code at a counted edge. It also holds the tick low, to catch a ramp that advances on the clock alone.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  typedef enum logic [1:0] {
    ST_WAIT    = 2'd0,
    ST_RUN     = 2'd1,
    ST_RECOVER = 2'd2
  } sfs_state_e;
endpackage

// File: rtl/sfs_ov_filter.sv
module sfs_ov_filter #(
  parameter int N = 80,
  localparam int W = $clog2(N + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic ov_i,
  output logic qual_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           cnt_q <= '0;
    else if (!ov_i)                        cnt_q <= '0;
    else if (tick_i && cnt_q != W'(N))     cnt_q <= cnt_q + 1'b1;
  end

  assign qual_o = (cnt_q == W'(N));
endmodule

// File: rtl/sfs_timer.sv
module sfs_timer #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (inc_i)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/sfs_softstart.sv
module sfs_softstart #(
  parameter int CODE_W = 8,
  parameter int STEP   = 39,
  localparam int DIV_W = $clog2(STEP + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              tick_i,
  output logic [CODE_W-1:0] code_o
);
  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      code_o <= '0;
    end else if (!run_i) begin
      div_q  <= '0;
      code_o <= '0;
    end else if (tick_i && code_o != {CODE_W{1'b1}}) begin
      if (div_q == DIV_W'(STEP - 1)) begin
        div_q  <= '0;
        code_o <= code_o + 1'b1;
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/switcher_fault_seq.sv
module switcher_fault_seq
  import sfs_pkg::*;
#(
  parameter int MS_TICKS  = 1000,
  parameter int FAULT_MS  = 48,
  parameter int OFF_MS    = 420,
  parameter int SS_MS     = 10,
  parameter int OVF_TICKS = 80,
  parameter int CODE_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rail_start_i,
  input  logic              rail_low_i,
  input  logic              rail_ov_i,
  input  logic              ilim_i,
  input  logic              tsd_i,
  input  logic              bo_i,
  output logic              drive_en_o,
  output logic [CODE_W-1:0] ipk_code_o,
  output logic [1:0]        state_o
);
  localparam int FAULT_TICKS = FAULT_MS * MS_TICKS;
  localparam int OFF_TICKS   = OFF_MS * MS_TICKS;
  localparam int SS_TICKS    = SS_MS * MS_TICKS;
  localparam int CODE_MAX    = (1 << CODE_W) - 1;
  localparam int SS_STEP_RAW = SS_TICKS / CODE_MAX;
  localparam int SS_STEP     = (SS_STEP_RAW < 1) ? 1 : SS_STEP_RAW;
  localparam int TMR_MAX     = (FAULT_TICKS > OFF_TICKS) ? FAULT_TICKS : OFF_TICKS;
  localparam int TMR_W       = $clog2(TMR_MAX + 1);

  sfs_state_e       state_q, state_d;
  logic [TMR_W-1:0] tmr_cnt;
  logic             tmr_clr, tmr_inc;
  logic             ov_qual, hard_stop, fault_done, off_done;

  sfs_ov_filter #(.N(OVF_TICKS)) u_ovf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .ov_i   (rail_ov_i),
    .qual_o (ov_qual)
  );

  assign hard_stop  = rail_low_i | tsd_i | bo_i;
  assign fault_done = ilim_i && tick_i && (tmr_cnt == TMR_W'(FAULT_TICKS - 1));
  assign off_done   = tick_i && (tmr_cnt == TMR_W'(OFF_TICKS - 1));

  // priority in run: hard stop, then over-voltage, then overload
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_WAIT:    if (rail_start_i && !hard_stop) state_d = ST_RUN;
      ST_RUN: begin
        if (hard_stop)       state_d = ST_WAIT;
        else if (ov_qual)    state_d = ST_RECOVER;
        else if (fault_done) state_d = ST_RECOVER;
      end
      ST_RECOVER: if (off_done) state_d = ST_WAIT;
      default:    state_d = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_WAIT;
    else         state_q <= state_d;
  end

  // one timer: overload window in run, off period in recovery
  assign tmr_clr = (state_d != state_q) || (state_q == ST_RUN && !ilim_i);
  assign tmr_inc = tick_i && ((state_q == ST_RECOVER) || (state_q == ST_RUN && ilim_i));

  sfs_timer #(.W(TMR_W)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (tmr_clr),
    .inc_i  (tmr_inc),
    .cnt_o  (tmr_cnt)
  );

  sfs_softstart #(.CODE_W(CODE_W), .STEP(SS_STEP)) u_ss (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (state_q == ST_RUN && state_d == ST_RUN),
    .tick_i (tick_i),
    .code_o (ipk_code_o)
  );

  assign drive_en_o = (state_q == ST_RUN);
  assign state_o    = state_q;
endmodule

// File: rtl/sfs_checker.sv
module sfs_checker #(
  parameter int CODE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rail_start_i,
  input logic              rail_low_i,
  input logic              tsd_i,
  input logic              bo_i,
  input logic              drive_en_o,
  input logic [CODE_W-1:0] ipk_code_o,
  input logic [1:0]        state_o
);
  assert_start_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drive_en_o) |-> ($past(rail_start_i) && !$past(rail_low_i) && !$past(tsd_i) && !$past(bo_i)));

  assert_ramp_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_en_o && $past(drive_en_o)) |->
      ((ipk_code_o == $past(ipk_code_o)) || (ipk_code_o == $past(ipk_code_o) + CODE_W'(1))));

  assert_code_zero_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drive_en_o |-> (ipk_code_o == '0));

  assert_recover_no_run_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd2) |=> (state_o != 2'd1));

  assert_rail_low_stop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_en_o && rail_low_i) |=> !drive_en_o);

  assert_tsd_bo_stop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_en_o && (tsd_i || bo_i)) |=> (state_o == 2'd0));
endmodule

bind switcher_fault_seq sfs_checker #(.CODE_W(CODE_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rail_start_i (rail_start_i),
  .rail_low_i   (rail_low_i),
  .tsd_i        (tsd_i),
  .bo_i         (bo_i),
  .drive_en_o   (drive_en_o),
  .ipk_code_o   (ipk_code_o),
  .state_o      (state_o)
);

// File: tb/switcher_fault_seq_tb.sv
`timescale 1ns/1ps
module switcher_fault_seq_tb_top;
  // 4 ticks/ms: fault 20, off 32, ramp step 4 ticks, code max 7, filter 3
  localparam int CW    = 3;
  localparam int FAULT = 20;
  localparam int OFF   = 32;
  localparam int STEP  = 4;
  localparam int OVF   = 3;

  logic clk = 1'b0, rst_ni = 1'b0, tick = 1'b1;
  logic rail_start = 1'b0, rail_low = 1'b0, rail_ov = 1'b0, ilim = 1'b0, tsd = 1'b0, bo = 1'b0;
  logic          drive_en;
  logic [CW-1:0] code;
  logic [1:0]    state;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  switcher_fault_seq #(
    .MS_TICKS(4), .FAULT_MS(5), .OFF_MS(8), .SS_MS(7), .OVF_TICKS(OVF), .CODE_W(CW)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .rail_start_i(rail_start),
    .rail_low_i(rail_low), .rail_ov_i(rail_ov), .ilim_i(ilim), .tsd_i(tsd), .bo_i(bo),
    .drive_en_o(drive_en), .ipk_code_o(code), .state_o(state)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_run(input string req, input int st, input int cd);
    chk(req, "state", state, st);
    chk(req, "drive", drive_en, (st == 1) ? 1 : 0);
    chk(req, "code", code, cd);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; tick = 1'b1;
    rail_start = 1'b1; rail_low = 0; rail_ov = 0; ilim = 0; tsd = 0; bo = 0;
    step(3);
    chk_run("R1", 0, 0);
    rail_start = 1'b0;
    rst_ni = 1'b1;
    step(1);
    chk_run("R1", 0, 0);
  endtask

  task automatic start_run();
    rail_start = 1'b1;
    step(1);
    chk_run("R2", 1, 0);
  endtask

  task automatic t_softstart();
    do_reset();
    start_run();
    tick = 1'b0;
    step(10);
    chk_run("R3", 1, 0);          // no ticks, no progress
    tick = 1'b1;
    step(STEP - 1);
    chk_run("R3", 1, 0);
    step(1);
    chk_run("R3", 1, 1);
    step(STEP * 6);
    chk_run("R3", 1, 7);
    step(STEP * 3);
    chk_run("R3", 1, 7);          // saturated
  endtask

  task automatic t_overload();
    do_reset();
    start_run();
    ilim = 1'b1;
    step(FAULT - 1);
    chk("R5", "state before trip", state, 1);
    step(1);
    chk_run("R5", 2, 0);
    step(OFF - 1);
    chk_run("R7", 2, 0);
    step(1);
    chk_run("R7", 0, 0);          // wait-for-start between attempts
    step(1);
    chk_run("R4", 1, 0);          // restart ramps from zero
    step(FAULT);
    chk_run("R7", 2, 0);          // burst repeats
    step(OFF + 1);
    chk_run("R7", 1, 0);
    ilim = 1'b0;
    step(40);
    chk_run("R7", 1, 7);          // fault cleared, keeps running
  endtask

  task automatic t_partial();
    do_reset();
    start_run();
    ilim = 1'b1;
    step(FAULT - 5);
    ilim = 1'b0;
    step(1);
    ilim = 1'b1;
    step(FAULT - 1);
    chk("R6", "state after gap", state, 1);
    step(1);
    chk("R6", "state trip", state, 2);
  endtask

  task automatic t_ov();
    do_reset();
    start_run();
    rail_ov = 1'b1;
    step(OVF - 1);
    rail_ov = 1'b0;
    step(5);
    chk("R8", "short pulse", state, 1);
    rail_ov = 1'b1;
    step(OVF);
    chk("R8", "filter running", state, 1);
    step(1);
    chk_run("R8", 2, 0);
    step(OFF);
    chk("R8", "back to wait", state, 0);
    step(1);
    chk_run("R8", 1, 0);          // restart attempt
    step(1);
    chk("R8", "persisting ov", state, 2);
    rail_ov = 1'b0;
  endtask

  task automatic t_rail_low();
    do_reset();
    start_run();
    step(8);
    rail_low = 1'b1;
    step(1);
    chk_run("R9", 0, 0);
    step(3);
    chk("R9", "held while low", state, 0);
    rail_low = 1'b0;
    step(1);
    chk_run("R9", 1, 0);
  endtask

  task automatic t_tsd_bo();
    do_reset();
    start_run();
    step(8);
    tsd = 1'b1;
    ilim = 1'b1;
    rail_ov = 1'b1;
    step(1);
    chk_run("R10", 0, 0);          // beats ov and overload
    rail_ov = 1'b0; ilim = 1'b0;
    step(5);
    chk("R10", "tsd blocks start", state, 0);
    tsd = 1'b0;
    step(1);
    chk_run("R10", 1, 0);
    bo = 1'b1;
    step(1);
    chk_run("R10", 0, 0);
    step(4);
    chk("R10", "bo blocks start", state, 0);
    bo = 1'b0;
    step(1);
    chk_run("R10", 1, 0);
  endtask

  initial begin
    t_softstart();
    t_overload();
    t_partial();
    t_ov();
    t_rail_low();
    t_tsd_bo();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule